// File: doc/BRIEF.md
# Chunk-Serial Long Divider

This block divides a wide unsigned dividend, made of `NUM_CHUNKS` pieces of `CHUNK_W` bits, by a divisor no wider than one piece. The only arithmetic it contains is a small core that divides a double-width value by a single-width divisor. The block runs that core once for each piece of the dividend. It starts at the most significant piece with a carried remainder of zero. For each piece, the carried remainder forms the upper half of a double-width value and the current piece forms the lower half. The core's quotient becomes the next piece of the quotient, and its remainder carries down to the next, less significant piece.

The carried remainder is always smaller than the divisor, so every per-piece quotient fits in one piece. The core is a restoring shift-and-subtract loop that retires one quotient bit per cycle.

A caller pulses `start` while the block is idle, with the dividend and divisor presented in parallel. It then waits for the one-cycle `done` pulse and reads the full quotient and the final remainder in parallel. A zero divisor is caught when `start` is sampled. In that case the block skips the iteration and reports an error result.

Top module: `chunk_long_div`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done` and `div_zero_err` are 0, and `quotient` and `remainder` are all zeros.
- R2: For a nonzero divisor, when `done` pulses, `quotient` equals the integer part of dividend divided by divisor, with the dividend taken as an unsigned number whose most significant piece is bits [TOTAL_W-1 -: CHUNK_W].
- R3: For a nonzero divisor, when `done` pulses, `remainder` equals dividend modulo divisor, which is always less than the divisor.
- R4: A start with a nonzero divisor raises `busy` from the next cycle. `busy` stays high until the cycle in which `done` rises. `done` is then high for exactly one cycle while `busy` is low.
- R5: A `start` pulse while `busy` is high is ignored, and changes to `dividend` or `divisor` after acceptance are ignored. The running result is unchanged and no extra `done` pulse appears.
- R6: A start with a divisor of zero never raises `busy`. In the next cycle it gives `done`=1, `div_zero_err`=1, a `quotient` of all ones and a `remainder` of zero.
- R7: An accepted start with a nonzero divisor clears `div_zero_err`, and the flag is 0 when that operation's `done` pulses.
- R8: For a nonzero divisor, `done` goes high exactly NUM_CHUNKS*(CHUNK_W+2) clock edges after the edge that samples `start`.
- R9: Boundary operands give exact results: an all-ones dividend with divisor 1 and with divisor 2^CHUNK_W-1, a zero dividend, and a dividend smaller than the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| dividend | input | CHUNK_W*NUM_CHUNKS | Unsigned dividend, sampled on accepted start |
| divisor | input | CHUNK_W | Unsigned divisor, sampled on accepted start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| div_zero_err | output | 1 | Last accepted operation had a zero divisor |
| quotient | output | CHUNK_W*NUM_CHUNKS | Full quotient |
| remainder | output | CHUNK_W | Final remainder |

## Verification
An error in the carried remainder corrupts the quotient piece for the current position and every less significant piece. It also corrupts the final remainder. It therefore shows up at `done` of the same operation, never later. A slip in the bit counter or the piece index changes the time from start to `done`, which the exact latency check catches on the first operation. A wrong shift or subtract in the core gives mismatched quotient bits that operands such as 6189/7, all-ones dividends and a stream of varied operands expose. A control state that accepts `start` while busy shows up as a changed result or a second `done` pulse.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_step_core.sv
// Restoring 2W/W divider; assumes hi < den so the quotient fits in W bits.
module div_step_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] den,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     lo;
        logic [W-1:0]     quo;
        logic             fin;
    } core_t;

    core_t s_q, s_d;
    logic [W:0] trial;
    logic       take;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        trial   = {s_q.rem, s_q.lo[W-1]};
        take    = (trial >= {1'b0, den});
        if (go) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(W);
            s_d.rem  = hi;
            s_d.lo   = lo;
            s_d.quo  = '0;
        end else if (s_q.busy) begin
            s_d.rem = take ? W'(trial - {1'b0, den}) : W'(trial);
            s_d.quo = {s_q.quo[W-2:0], take};
            s_d.lo  = {s_q.lo[W-2:0], 1'b0};
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fin = s_q.fin;
    assign quo = s_q.quo;
    assign rem = s_q.rem;
endmodule

// File: rtl/div_chunk_shreg.sv
// Piece-wide shift register: parallel load, shift left by one piece.
module div_chunk_shreg #(
    parameter int CHUNK_W    = 8,
    parameter int NUM_CHUNKS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [CHUNK_W*NUM_CHUNKS-1:0] load_val,
    input  logic                          shift,
    input  logic [CHUNK_W-1:0]            shift_in,
    output logic [CHUNK_W*NUM_CHUNKS-1:0] value
);
    localparam int TOTAL_W = CHUNK_W * NUM_CHUNKS;

    logic [TOTAL_W-1:0] val_q, val_d;

    always_comb begin
        val_d = val_q;
        if (load)       val_d = load_val;
        else if (shift) val_d = {val_q[TOTAL_W-CHUNK_W-1:0], shift_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/chunk_long_div.sv
module chunk_long_div
    import div_pkg::*;
#(
    parameter int CHUNK_W    = 8,
    parameter int NUM_CHUNKS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [CHUNK_W*NUM_CHUNKS-1:0] dividend,
    input  logic [CHUNK_W-1:0]            divisor,
    output logic                          busy,
    output logic                          done,
    output logic                          div_zero_err,
    output logic [CHUNK_W*NUM_CHUNKS-1:0] quotient,
    output logic [CHUNK_W-1:0]            remainder
);
    localparam int TOTAL_W = CHUNK_W * NUM_CHUNKS;
    localparam int IDX_W   = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;

    typedef struct packed {
        div_state_e         state;
        logic [IDX_W-1:0]   idx;
        logic [CHUNK_W-1:0] carry;
        logic [CHUNK_W-1:0] den;
        logic               done;
        logic               err;
    } ctl_t;

    ctl_t s_q, s_d;

    logic               step_go, step_fin;
    logic [CHUNK_W-1:0] step_quo, step_rem;
    logic               dvd_load, dvd_shift;
    logic [TOTAL_W-1:0] dvd_val;
    logic               quo_load, quo_shift;
    logic [TOTAL_W-1:0] quo_load_val, quo_val;

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        step_go      = 1'b0;
        dvd_load     = 1'b0;
        dvd_shift    = 1'b0;
        quo_load     = 1'b0;
        quo_load_val = '0;
        quo_shift    = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    quo_load  = 1'b1;
                    s_d.carry = '0;
                    if (divisor == '0) begin
                        quo_load_val = '1;
                        s_d.err      = 1'b1;
                        s_d.done     = 1'b1;
                    end else begin
                        dvd_load  = 1'b1;
                        s_d.err   = 1'b0;
                        s_d.den   = divisor;
                        s_d.idx   = IDX_W'(NUM_CHUNKS - 1);
                        s_d.state = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                step_go   = 1'b1;
                s_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (step_fin) begin
                    s_d.carry = step_rem;
                    dvd_shift = 1'b1;
                    quo_shift = 1'b1;
                    if (s_q.idx == '0) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.idx   = s_q.idx - IDX_W'(1);
                        s_d.state = ST_ISSUE;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    div_step_core #(.W(CHUNK_W)) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (step_go),
        .hi   (s_q.carry),
        .lo   (dvd_val[TOTAL_W-1 -: CHUNK_W]),
        .den  (s_q.den),
        .fin  (step_fin),
        .quo  (step_quo),
        .rem  (step_rem)
    );

    div_chunk_shreg #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)) u_dvd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dvd_load),
        .load_val(dividend),
        .shift   (dvd_shift),
        .shift_in('0),
        .value   (dvd_val)
    );

    div_chunk_shreg #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)) u_quo (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (quo_load),
        .load_val(quo_load_val),
        .shift   (quo_shift),
        .shift_in(step_quo),
        .value   (quo_val)
    );

    assign busy         = (s_q.state != ST_IDLE);
    assign done         = s_q.done;
    assign div_zero_err = s_q.err;
    assign quotient     = quo_val;
    assign remainder    = s_q.carry;
endmodule

// File: rtl/chunk_long_div_chk.sv
module chunk_long_div_chk #(
    parameter int CHUNK_W    = 8,
    parameter int NUM_CHUNKS = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic [CHUNK_W-1:0]            divisor,
    input logic                          busy,
    input logic                          done,
    input logic                          div_zero_err,
    input logic [CHUNK_W*NUM_CHUNKS-1:0] quotient,
    input logic [CHUNK_W-1:0]            remainder
);
    localparam int LAT = NUM_CHUNKS * (CHUNK_W + 2);

    logic [CHUNK_W-1:0] den_seen_q;
    logic [31:0]        lat_q;
    logic               accept;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            den_seen_q <= '0;
            lat_q      <= '0;
        end else begin
            if (accept) begin
                den_seen_q <= divisor;
                lat_q      <= '0;
            end else if (busy) begin
                lat_q <= lat_q + 32'd1;
            end
        end
    end

    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
    p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && divisor != '0) |=> busy);
    p_rem_below_den_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero_err) |-> (remainder < den_seen_q));
    p_zero_den_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && divisor == '0) |=> (done && div_zero_err && !busy && quotient == '1));
    p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && divisor != '0) |=> !div_zero_err);
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero_err) |-> (lat_q == 32'(LAT)));
endmodule

bind chunk_long_div chunk_long_div_chk #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .div_zero_err(div_zero_err),
    .quotient    (quotient),
    .remainder   (remainder)
);

// File: tb/sim_chunk_long_div.sv
`timescale 1ns/1ps
module sim_chunk_long_div;
    localparam int CW  = 8;
    localparam int NC  = 4;
    localparam int TW  = CW * NC;
    localparam int LAT = NC * (CW + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [TW-1:0] dividend = '0;
    logic [CW-1:0] divisor = '0;
    logic          busy, done, div_zero_err;
    logic [TW-1:0] quotient;
    logic [CW-1:0] remainder;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        logic [TW-1:0] q;
        logic [CW-1:0] r;
        logic          e;
        int            t0;
    } exp_t;
    exp_t sbq[$];

    chunk_long_div #(.CHUNK_W(CW), .NUM_CHUNKS(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done),
        .div_zero_err(div_zero_err), .quotient(quotient), .remainder(remainder)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop expected item on every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R5 unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t x;
                x = sbq.pop_front();
                chk(quotient == x.q, "R2 quotient", 64'(quotient), 64'(x.q));
                chk(remainder == x.r, "R3 remainder", 64'(remainder), 64'(x.r));
                chk(div_zero_err == x.e, "R6/R7 error flag", 64'(div_zero_err), 64'(x.e));
                chk((cyc - x.t0) == (x.e ? 0 : LAT), "R8 latency",
                    64'(cyc - x.t0), 64'(x.e ? 0 : LAT));
            end
        end
    end

    task automatic run_op(input logic [TW-1:0] a, input logic [CW-1:0] b);
        exp_t x;
        x.e  = (b == '0);
        x.q  = x.e ? '1 : a / TW'(b);
        x.r  = x.e ? '0 : CW'(a % TW'(b));
        x.t0 = cyc + 1;
        sbq.push_back(x);
        start = 1'b1; dividend = a; divisor = b;
        @(negedge clk);
        start = 1'b0;
        if (x.e) chk(!busy, "R6 busy stays low", 64'(busy), 64'd0);
        else     chk(busy, "R4 busy after start", 64'(busy), 64'd1);
        while (!done) @(negedge clk);
        chk(!busy, "R4 busy low at done", 64'(busy), 64'd0);
        @(negedge clk);
        chk(!done, "R4 done single cycle", 64'(done), 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] s;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !div_zero_err, "R1 flags in reset", {busy, done, div_zero_err}, 64'd0);
        chk(quotient == '0 && remainder == '0, "R1 data in reset", 64'(quotient), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !div_zero_err, "R1 flags after reset", {busy, done, div_zero_err}, 64'd0);

        run_op(32'd6189, 8'd7);           // R2 R3 decimal example
        run_op(32'd94, 8'd7);
        run_op(32'h1234_5678, 8'h9A);
        run_op(32'hFFFF_FFFF, 8'd1);      // R9
        run_op(32'hFFFF_FFFF, 8'hFF);     // R9
        run_op(32'd0, 8'd5);              // R9
        run_op(32'd5, 8'd200);            // R9 dividend < divisor
        run_op(32'hDEAD_BEEF, 8'd0);      // R6
        run_op(32'hDEAD_BEEF, 8'd3);      // R7 clears error
        run_op(32'h8000_0000, 8'h80);

        // R5: start and operand changes while busy are ignored
        begin
            exp_t x;
            x.e = 1'b0; x.q = 32'hCAFE_F00D / 32'd13; x.r = 8'(32'hCAFE_F00D % 32'd13);
            x.t0 = cyc + 1;
            sbq.push_back(x);
            start = 1'b1; dividend = 32'hCAFE_F00D; divisor = 8'd13;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            start = 1'b1; dividend = 32'h1111_1111; divisor = 8'd0;
            @(negedge clk);
            start = 1'b0; divisor = 8'd99;
            while (!done) @(negedge clk);
            repeat (4) @(negedge clk);
            chk(sbq.size() == 0 && !busy, "R5 no extra operation", 64'(sbq.size()), 64'd0);
        end

        s = 32'h1357_9BDF;
        for (int i = 0; i < 24; i++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            run_op(s, s[15:8] ^ s[7:0]);
        end

        repeat (5) @(negedge clk);
        chk(sbq.size() == 0, "R4 all results seen", 64'(sbq.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule